// File: doc/BRIEF.md
# UART Receive Character Buffer

This block is the receive-side store of a UART. The deserializer pushes each received character into it together with four error flags, or pushes a line-break indication. A bus read of the receive data register pops the oldest entry. The buffer shows that entry on its output. It also gives empty and full flags, a ready signal back to the deserializer, a latched copy of the error flags of the last popped character, and a receive interrupt request.

A mode input chooses between buffered operation, which holds up to sixteen entries, and single-entry holding-register operation. Any change of the mode input discards the stored contents. The interrupt request has a trigger level of one entry. It is set when a push brings the occupancy up to the trigger level, and cleared when a pop leaves the occupancy one below it.

Top module: `rx_char_fifo`

## Requirements
- R1: After reset, `empty`=1, `full`=0, `ready`=1, `rx_irq`=0, `rx_status`=0, and every stored entry, including the one shown on `head`, is 12'h000.
- R2: With `fifo_en`=1 the buffer holds up to 16 entries and returns them in push order. `full` is 1 exactly when 16 entries are held, and `empty` is 1 exactly when none are held.
- R3: An entry is 12 bits wide: bits 11:8 are `push_err` and bits 7:0 are `push_char`. A push with `push_break`=1 stores 12'h400 whatever the character and error inputs are. `head` shows the entry at the read position.
- R4: With `fifo_en`=0 the buffer holds a single entry, and `full` is 1 after one push.
- R5: `ready` is 1 while the held count is below the active capacity (16 or 1). A push while `ready`=0 is dropped and changes no state.
- R6: In a cycle where `fifo_en` differs from its value in the previous cycle, the count and read position return to zero, and that cycle's push and pop have no effect. `rx_irq` and `rx_status` are left unchanged. The register that holds the previous value starts at 0 after reset.
- R7: `rx_irq` is set by an accepted push that leaves the count at 1. It is cleared by a pop that leaves the count at 0, and this includes a pop of an empty buffer.
- R8: Every pop copies bits 11:8 of the `head` entry into `rx_status`. A pop of an empty buffer leaves the read position unchanged, so `head` keeps its value.
- R9: `status_clr`=1 sets `rx_status` to 0. When a pop occurs in the same cycle, the pop's capture takes effect instead.
- R10: A push and a pop in the same cycle, with the buffer neither full nor empty, leave the count unchanged and advance the read position by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1: sixteen-entry buffer, 0: single holding entry |
| push_valid | input | 1 | Deserializer offers an entry |
| push_char | input | 8 | Received character |
| push_err | input | 4 | Per-character error flags |
| push_break | input | 1 | Store a break entry instead |
| ready | output | 1 | Buffer can accept a push |
| pop | input | 1 | Data-register read strobe |
| status_clr | input | 1 | Clear the receive-status register |
| head | output | 12 | Entry at the read position |
| rx_status | output | 4 | Error flags of the last popped entry |
| empty | output | 1 | No entries held |
| full | output | 1 | Active capacity reached |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions check on every cycle the following points:
- `empty` and `full` are never high together.
- The count stays within the capacity.
- A dropped push leaves the count alone.
- A pop of an empty buffer does not move the read position.
- The interrupt only rises after a push.
- A status clear without a pop yields zero.

Only the bench's scenarios can show the rest:
- Entries come back in push order with their error bits and break tags intact.
- A mode change discards data while the interrupt keeps its value.
- A pop in the same cycle as a status clear wins.

// File: rtl/rx_char_fifo.sv
module rx_char_fifo #(
  parameter int DEPTH = 16,
  parameter int CW    = 8,
  parameter int EW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push_valid,
  input  logic [CW-1:0] push_char,
  input  logic [EW-1:0] push_err,
  input  logic          push_break,
  output logic          ready,
  input  logic          pop,
  input  logic          status_clr,
  output logic [CW+EW-1:0] head,
  output logic [EW-1:0] rx_status,
  output logic          empty,
  output logic          full,
  output logic          rx_irq
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CNTW = AW + 1;
  localparam int ENTW = CW + EW;
  localparam logic [ENTW-1:0] BREAK_ENT = ENTW'(1) << (CW + 2);
  localparam logic [CNTW-1:0] CAP_BUF  = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] CAP_HOLD = CNTW'(1);

  logic [ENTW-1:0] mem [DEPTH];
  logic [AW-1:0]   rd_ptr;
  logic [CNTW-1:0] count, cnt_n, cap;
  logic            en_q, irq_q;
  logic [EW-1:0]   sts_q;

  wire flush    = fifo_en ^ en_q;
  assign cap    = en_q ? CAP_BUF : CAP_HOLD;
  assign ready  = count < cap;
  assign empty  = count == '0;
  assign full   = count == cap;
  assign head   = mem[rd_ptr];
  assign rx_status = sts_q;
  assign rx_irq = irq_q;

  wire push_ok = push_valid && ready && !flush;
  wire pop_ok  = pop && !flush;
  wire pop_mv  = pop_ok && !empty;
  wire [AW-1:0] wr_ptr = rd_ptr + count[AW-1:0];

  always_comb begin
    cnt_n = count;
    if (push_ok) cnt_n = cnt_n + CNTW'(1);
    if (pop_mv)  cnt_n = cnt_n - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      count  <= '0;
      rd_ptr <= '0;
      irq_q  <= 1'b0;
      sts_q  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      en_q <= fifo_en;
      if (flush) begin
        count  <= '0;
        rd_ptr <= '0;
      end else begin
        count <= cnt_n;
        if (pop_mv) rd_ptr <= rd_ptr + AW'(1);
      end
      if (push_ok) mem[wr_ptr] <= push_break ? BREAK_ENT : {push_err, push_char};
      if (pop_ok) sts_q <= head[ENTW-1:CW];
      else if (status_clr) sts_q <= '0;
      if (push_ok && cnt_n == CNTW'(1)) irq_q <= 1'b1;
      else if (pop_ok && cnt_n == '0) irq_q <= 1'b0;
    end
  end

  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(empty && full));
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP_BUF);
  assert_drop_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !ready && !pop && !flush) |=> $stable(count));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push_valid && !flush) |=> $stable(head));
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(push_valid));
  assert_status_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !pop) |=> rx_status == '0);
endmodule

// File: tb/tb_rx_char_fifo.sv
`timescale 1ns/1ps
module tb_rx_char_fifo;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 0, push_valid = 0, push_break = 0, pop = 0, status_clr = 0;
  logic [7:0] push_char = 0;
  logic [3:0] push_err = 0;
  logic ready, empty, full, rx_irq;
  logic [11:0] head;
  logic [3:0] rx_status;
  int total = 0, bad = 0;
  bit done = 0;

  rx_char_fifo dut (.clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .push_valid(push_valid),
    .push_char(push_char), .push_err(push_err), .push_break(push_break), .ready(ready),
    .pop(pop), .status_clr(status_clr), .head(head), .rx_status(rx_status),
    .empty(empty), .full(full), .rx_irq(rx_irq));

  always #10 clk = ~clk;

  logic [11:0] m_mem [16];
  int m_cnt = 0, m_rd = 0;
  bit m_en_q = 0, m_irq = 0;
  logic [3:0] m_sts = 0;

  function automatic int m_cap(bit en);
    return en ? 16 : 1;
  endfunction

  function automatic logic [11:0] m_entry(bit brk, logic [3:0] e, logic [7:0] c);
    return brk ? 12'h400 : {e, c};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R2 empty", 32'(empty), 32'(m_cnt == 0));
    check("R2 full", 32'(full), 32'(m_cnt == m_cap(m_en_q)));
    check("R5 ready", 32'(ready), 32'(m_cnt < m_cap(m_en_q)));
    check("R7 irq", 32'(rx_irq), 32'(m_irq));
    check("R8 status", 32'(rx_status), 32'(m_sts));
    check("R3 head", 32'(head), 32'(m_mem[m_rd]));
  endtask

  task automatic step(bit pv, logic [7:0] pc, logic [3:0] pe, bit pb, bit pp, bit clr, bit fe);
    bit flush, pok, pok2, mv;
    int ncnt;
    logic [11:0] hd;
    push_valid = pv; push_char = pc; push_err = pe; push_break = pb;
    pop = pp; status_clr = clr; fifo_en = fe;
    flush = (fe != m_en_q);
    pok  = pv && (m_cnt < m_cap(m_en_q)) && !flush;
    pok2 = pp && !flush;
    mv   = pok2 && (m_cnt > 0);
    hd   = m_mem[m_rd];
    if (pok) m_mem[(m_rd + m_cnt) % 16] = m_entry(pb, pe, pc);
    ncnt = m_cnt + int'(pok) - int'(mv);
    if (pok2) m_sts = hd[11:8];
    else if (clr) m_sts = 4'h0;
    if (pok && ncnt == 1) m_irq = 1;
    else if (pok2 && ncnt == 0) m_irq = 0;
    if (flush) begin m_cnt = 0; m_rd = 0; end
    else begin m_cnt = ncnt; if (mv) m_rd = (m_rd + 1) % 16; end
    m_en_q = fe;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(bit fe);
    step(0, 8'h00, 4'h0, 0, 0, 0, fe);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 12'h000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", 32'(empty), 32'd1);
    check("R1 full", 32'(full), 32'd0);
    check("R1 ready", 32'(ready), 32'd1);
    check("R1 irq", 32'(rx_irq), 32'd0);
    check("R1 status", 32'(rx_status), 32'd0);
    check("R1 head", 32'(head), 32'd0);

    // R2: switch to buffered mode, fill 16, then a dropped 17th (R5)
    idle(1);
    for (int i = 0; i < 16; i++) step(1, 8'(8'h30 + i), 4'(i), 0, 0, 0, 1);
    check("R2 full after 16", 32'(full), 32'd1);
    check("R5 ready low", 32'(ready), 32'd0);
    step(1, 8'hEE, 4'hF, 0, 0, 0, 1);
    check("R5 dropped head", 32'(head), 32'h030);
    for (int i = 0; i < 16; i++) begin
      check("R2 order", 32'(head), 32'({4'(i), 8'(8'h30 + i)}));
      step(0, 8'h00, 4'h0, 0, 1, 0, 1);
    end
    check("R7 irq cleared", 32'(rx_irq), 32'd0);

    // R3 break entry
    step(1, 8'h5A, 4'h3, 1, 0, 0, 1);
    check("R3 break entry", 32'(head), 32'h400);
    check("R7 irq set", 32'(rx_irq), 32'd1);
    step(0, 8'h00, 4'h0, 0, 1, 0, 1);
    check("R8 status break", 32'(rx_status), 32'h4);
    // R8 pop on empty: head unchanged, status recaptured, irq stays low
    step(0, 8'h00, 4'h0, 0, 1, 0, 1);
    check("R8 empty pop status", 32'(rx_status), 32'(m_mem[m_rd][11:8]));
    // R9 clear, and pop wins over clear
    step(0, 8'h00, 4'h0, 0, 0, 1, 1);
    check("R9 cleared", 32'(rx_status), 32'd0);
    step(1, 8'h11, 4'h9, 0, 0, 0, 1);
    step(0, 8'h00, 4'h0, 0, 1, 1, 1);
    check("R9 pop wins", 32'(rx_status), 32'h9);

    // R10 simultaneous push and pop
    step(1, 8'h01, 4'h1, 0, 0, 0, 1);
    step(1, 8'h02, 4'h2, 0, 0, 0, 1);
    step(1, 8'h03, 4'h3, 0, 1, 0, 1);
    check("R10 head advanced", 32'(head), 32'h202);
    check("R10 not empty", 32'(empty), 32'd0);

    // R6 flush on mode change keeps irq
    step(1, 8'h77, 4'h0, 0, 1, 0, 0);
    check("R6 flushed empty", 32'(empty), 32'd1);
    check("R6 irq kept", 32'(rx_irq), 32'd1);
    // R4 holding-register mode
    step(1, 8'h44, 4'h0, 0, 0, 0, 0);
    check("R4 full after one", 32'(full), 32'd1);
    step(1, 8'h45, 4'h0, 0, 0, 0, 0);
    check("R4 second dropped", 32'(head), 32'h044);
    step(0, 8'h00, 4'h0, 0, 1, 0, 0);
    check("R4 empty after pop", 32'(empty), 32'd1);

    // randomized mix
    void'($urandom(32'd12345));
    begin
      bit fe = 0;
      for (int n = 0; n < 4000; n++) begin
        bit pv, pb, pp, clr;
        logic [31:0] r = $urandom;
        if (r[9:0] == 10'd7) fe = !fe;
        pv  = r[12:11] != 2'b00;
        pb  = r[17:15] == 3'd0;
        pp  = r[19:18] == 2'b00 || (r[19:18] == 2'b01 && n[8]);
        clr = r[22:20] == 3'd1;
        step(pv, r[30:23], r[14:11], pb, pp, clr, fe);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule